// File: doc/BRIEF.md
# Vectored Interrupt Acceptance Unit

This block sits inside a processor core and settles, at each instruction boundary, whether a pending interrupt is taken, what kind it is, and where execution continues. It holds the two interrupt enable flags (a live flag and a shadow copy) and the current interrupt mode. It also holds a latch that captures a falling edge on the non-maskable request. The maskable request is sampled as a level. The core supplies a boundary strobe together with the decoded control events of the instruction that just completed: enable, disable, mode select and return-from-non-maskable.

When an interrupt is taken, the unit raises a one-cycle accept pulse and a push-PC request. At the same time it presents the interrupt kind and a 16-bit target. For the non-maskable interrupt and for mode 1, the target is a fixed handler address. For mode 2, the target is a table pointer built from the page register and the device byte, and the core's memory sequencer reads the handler word from that pointer. For mode 0, the target is zero and the kind tells the core that it must fetch an opcode from the bus.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset, accept and push_pc are low, both enable flags are 0, the mode is 0 and no non-maskable request is pending.
- R2: Control events and requests are acted on only in a cycle where `boundary` is high. Events presented without `boundary` have no effect.
- R3: A falling edge on `nmi_n` sets a pending latch that persists until it is accepted. Acceptance clears the latch, and holding `nmi_n` low does not set it again; a new falling edge is needed.
- R4: A pending non-maskable request is taken at a boundary regardless of the enable flags, and it wins over a simultaneous maskable request.
- R5: A taken non-maskable interrupt reports kind 0 and target 0x0066. It copies the live flag into the shadow flag and clears the live flag.
- R6: The maskable request is taken at a boundary only if `int_n` is low at that boundary and the live flag is set. It is not latched.
- R7: The enable event sets both flags and the disable event clears both flags. A maskable request is not taken at the boundary that carries the enable event.
- R8: The mode event loads `im_sel` values 0, 1 or 2 into the mode. Code 3 leaves the mode unchanged.
- R9: Kind codes are 1 for mode 0 (target 0x0000), 2 for mode 1 (target 0x0038) and 3 for mode 2. In mode 2 the target is `{i_reg, dev_vec}`, with the device byte passed unaltered.
- R10: Taking a maskable interrupt clears both enable flags.
- R11: The return-from-non-maskable event copies the shadow flag into the live flag.
- R12: `accept` and `push_pc` are single-cycle pulses that appear in the cycle after the deciding boundary. `kind` and `target` are valid with them. Events and flags at a boundary are applied before the decision at that same boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_n | input | 1 | Maskable request, active low level |
| nmi_n | input | 1 | Non-maskable request, falling edge |
| boundary | input | 1 | End-of-instruction strobe |
| ev_ei | input | 1 | Enable event of the completing instruction |
| ev_di | input | 1 | Disable event |
| ev_retn | input | 1 | Return-from-non-maskable event |
| ev_im | input | 1 | Mode select event |
| im_sel | input | 2 | Requested mode for ev_im |
| i_reg | input | 8 | Vector page register |
| dev_vec | input | 8 | Vector byte from the interrupting device |
| accept | output | 1 | Interrupt taken pulse |
| push_pc | output | 1 | Request to push the current PC |
| kind | output | 2 | 0 NMI, 1 mode 0, 2 mode 1, 3 mode 2 |
| target | output | 16 | Handler address or table pointer |
| iff1 | output | 1 | Live enable flag |
| iff2 | output | 1 | Shadow enable flag |
| mode | output | 2 | Current interrupt mode |

## Verification
Two things can fall on the same boundary. The first is a latched non-maskable request together with a low maskable level: the bench arms both and checks that only kind 0 is reported and that the shadow flag captured the live flag. The second is a control event together with the maskable decision. The bench sets enable, disable or return events on the same boundary as a low `int_n` and judges acceptance against the flag values after the event. Mode 2 pointer formation is swept over all 256 device bytes.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
    typedef enum logic [1:0] {
        KIND_NMI = 2'd0,
        KIND_IM0 = 2'd1,
        KIND_IM1 = 2'd2,
        KIND_IM2 = 2'd3
    } irq_kind_e;

    localparam logic [1:0] MODE_0 = 2'd0;
    localparam logic [1:0] MODE_1 = 2'd1;
    localparam logic [1:0] MODE_2 = 2'd2;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic take,
    output logic pending
);
    typedef struct packed {
        logic prev;
        logic pend;
    } nmi_state_t;

    nmi_state_t st_d, st_q;
    logic fall;

    always_comb begin
        fall = st_q.prev & ~nmi_n;
        st_d.prev = nmi_n;
        st_d.pend = fall | (st_q.pend & ~take);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{prev: 1'b1, pend: 1'b0};
        else        st_q <= st_d;
    end

    assign pending = st_q.pend;

    // R3
    nmi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take && !fall |=> !pending);
    // R3
    nmi_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> $past(fall));
endmodule

// File: rtl/irq_enable_ctl.sv
module irq_enable_ctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       boundary,
    input  logic       ev_ei,
    input  logic       ev_di,
    input  logic       ev_retn,
    input  logic       ev_im,
    input  logic [1:0] im_sel,
    input  logic       take_nmi,
    input  logic       take_int,
    output logic       iff1_q_o,
    output logic       iff2_q_o,
    output logic [1:0] mode_q_o,
    output logic       iff1_eff,
    output logic [1:0] mode_eff
);
    import irq_accept_pkg::*;

    typedef struct packed {
        logic       iff1;
        logic       iff2;
        logic [1:0] mode;
    } en_state_t;

    en_state_t st_d, st_q, st_e;

    always_comb begin
        st_e = st_q;
        if (boundary) begin
            if (ev_ei) begin
                st_e.iff1 = 1'b1;
                st_e.iff2 = 1'b1;
            end
            if (ev_di) begin
                st_e.iff1 = 1'b0;
                st_e.iff2 = 1'b0;
            end
            if (ev_retn) st_e.iff1 = st_q.iff2;
            if (ev_im && im_sel != 2'd3) st_e.mode = im_sel;
        end
        st_d = st_e;
        if (take_nmi) begin
            st_d.iff2 = st_e.iff1;
            st_d.iff1 = 1'b0;
        end else if (take_int) begin
            st_d.iff1 = 1'b0;
            st_d.iff2 = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{iff1: 1'b0, iff2: 1'b0, mode: MODE_0};
        else        st_q <= st_d;
    end

    assign iff1_q_o = st_q.iff1;
    assign iff2_q_o = st_q.iff2;
    assign mode_q_o = st_q.mode;
    assign iff1_eff = st_e.iff1;
    assign mode_eff = st_e.mode;

    // R10
    int_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_int |=> !iff1_q_o && !iff2_q_o);
    // R5
    nmi_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi |=> !iff1_q_o && (iff2_q_o == $past(iff1_eff)));
    // R8
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q_o != 2'd3);
    // R2
    no_event_off_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(iff1_q_o) && $stable(mode_q_o));
endmodule

// File: rtl/irq_target_gen.sv
module irq_target_gen #(
    parameter int PAGE_W   = 8,
    parameter int VEC_W    = 8,
    parameter int NMI_HDL  = 'h0066,
    parameter int RST_HDL  = 'h0038,
    localparam int ADDR_W  = PAGE_W + VEC_W
) (
    input  irq_accept_pkg::irq_kind_e kind,
    input  logic [PAGE_W-1:0]         page,
    input  logic [VEC_W-1:0]          vec,
    output logic [ADDR_W-1:0]         target
);
    import irq_accept_pkg::*;

    always_comb begin
        unique case (kind)
            KIND_NMI: target = ADDR_W'(NMI_HDL);
            KIND_IM1: target = ADDR_W'(RST_HDL);
            KIND_IM2: target = {page, vec};
            default:  target = '0;
        endcase
    end
endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit #(
    parameter int PAGE_W = 8,
    parameter int VEC_W  = 8,
    localparam int ADDR_W = PAGE_W + VEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_n,
    input  logic              nmi_n,
    input  logic              boundary,
    input  logic              ev_ei,
    input  logic              ev_di,
    input  logic              ev_retn,
    input  logic              ev_im,
    input  logic [1:0]        im_sel,
    input  logic [PAGE_W-1:0] i_reg,
    input  logic [VEC_W-1:0]  dev_vec,
    output logic              accept,
    output logic              push_pc,
    output logic [1:0]        kind,
    output logic [ADDR_W-1:0] target,
    output logic              iff1,
    output logic              iff2,
    output logic [1:0]        mode
);
    import irq_accept_pkg::*;

    typedef struct packed {
        logic              accept;
        logic              push;
        irq_kind_e         kind;
        logic [ADDR_W-1:0] target;
    } out_state_t;

    out_state_t st_d, st_q;
    logic       nmi_pend, take_nmi, take_int, iff1_eff;
    logic [1:0] mode_eff;
    irq_kind_e  kind_now;
    logic [ADDR_W-1:0] target_now;

    irq_nmi_latch u_nmi (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n),
        .take(take_nmi), .pending(nmi_pend)
    );

    irq_enable_ctl u_en (
        .clk(clk), .rst_n(rst_n), .boundary(boundary),
        .ev_ei(ev_ei), .ev_di(ev_di), .ev_retn(ev_retn),
        .ev_im(ev_im), .im_sel(im_sel),
        .take_nmi(take_nmi), .take_int(take_int),
        .iff1_q_o(iff1), .iff2_q_o(iff2), .mode_q_o(mode),
        .iff1_eff(iff1_eff), .mode_eff(mode_eff)
    );

    irq_target_gen #(.PAGE_W(PAGE_W), .VEC_W(VEC_W)) u_tgt (
        .kind(kind_now), .page(i_reg), .vec(dev_vec), .target(target_now)
    );

    always_comb begin
        take_nmi = boundary & nmi_pend;
        take_int = boundary & ~nmi_pend & ~int_n & iff1_eff & ~ev_ei;
        if (take_nmi)                kind_now = KIND_NMI;
        else if (mode_eff == MODE_1) kind_now = KIND_IM1;
        else if (mode_eff == MODE_2) kind_now = KIND_IM2;
        else                         kind_now = KIND_IM0;
        st_d.accept = take_nmi | take_int;
        st_d.push   = take_nmi | take_int;
        st_d.kind   = kind_now;
        st_d.target = target_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{accept: 1'b0, push: 1'b0, kind: KIND_NMI, target: '0};
        else        st_q <= st_d;
    end

    assign accept  = st_q.accept;
    assign push_pc = st_q.push;
    assign kind    = st_q.kind;
    assign target  = st_q.target;

    // R4
    nmi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary && nmi_pend |=> accept && kind == KIND_NMI);
    // R12
    accept_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(boundary));
    // R9
    im2_pointer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && kind == KIND_IM2 |-> target == {$past(i_reg), $past(dev_vec)});
    // R7
    ei_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && kind != KIND_NMI |-> !$past(ev_ei));
    // R6
    int_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary && int_n && !nmi_pend |=> !accept);
endmodule

// File: tb/sim_irq_accept_unit.sv
module sim_irq_accept_unit;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic int_n = 1'b1, nmi_n = 1'b1, boundary = 1'b0;
    logic ev_ei = 1'b0, ev_di = 1'b0, ev_retn = 1'b0, ev_im = 1'b0;
    logic [1:0] im_sel = 2'd0;
    logic [7:0] i_reg = 8'h00, dev_vec = 8'h00;
    logic accept, push_pc, iff1, iff2;
    logic [1:0] kind, mode;
    logic [15:0] target;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_accept_unit u0 (
        .clk(clk), .rst_n(rst_n), .int_n(int_n), .nmi_n(nmi_n),
        .boundary(boundary), .ev_ei(ev_ei), .ev_di(ev_di), .ev_retn(ev_retn),
        .ev_im(ev_im), .im_sel(im_sel), .i_reg(i_reg), .dev_vec(dev_vec),
        .accept(accept), .push_pc(push_pc), .kind(kind), .target(target),
        .iff1(iff1), .iff2(iff2), .mode(mode)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one boundary cycle with the given events; outputs sampled just after the edge
    task automatic bnd(input logic ei, input logic di, input logic retn,
                       input logic im, input logic [1:0] sel);
        @(negedge clk);
        boundary = 1'b1; ev_ei = ei; ev_di = di; ev_retn = retn;
        ev_im = im; im_sel = sel;
        @(posedge clk); #1;
        boundary = 1'b0; ev_ei = 1'b0; ev_di = 1'b0; ev_retn = 1'b0; ev_im = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 accept", accept, 0);
        chk("R1 push_pc", push_pc, 0);
        chk("R1 iff1", iff1, 0);
        chk("R1 iff2", iff2, 0);
        chk("R1 mode", mode, 0);
        int_n = 1'b0;
        bnd(0, 0, 0, 0, 2'd0);
        chk("R1 R6 no pending nmi, iff1 clear", accept, 0);

        // R7 enable boundary blocks INT
        bnd(1, 0, 0, 0, 2'd0);
        chk("R7 ei boundary blocked", accept, 0);
        chk("R7 ei iff1", iff1, 1);
        chk("R7 ei iff2", iff2, 1);
        // R9 mode 0 acceptance
        bnd(0, 0, 0, 0, 2'd0);
        chk("R6 int taken", accept, 1);
        chk("R12 push_pc", push_pc, 1);
        chk("R9 kind m0", kind, 1);
        chk("R9 target m0", target, 16'h0000);
        chk("R10 iff1 cleared", iff1, 0);
        chk("R10 iff2 cleared", iff2, 0);
        idle(1);
        chk("R12 single pulse", accept, 0);
        chk("R12 push single pulse", push_pc, 0);

        // R2 events without boundary ignored
        @(negedge clk); ev_ei = 1'b1; ev_im = 1'b1; im_sel = 2'd2;
        @(posedge clk); #1; ev_ei = 1'b0; ev_im = 1'b0;
        chk("R2 iff1 untouched", iff1, 0);
        chk("R2 mode untouched", mode, 0);
        bnd(1, 0, 0, 1, 2'd1);
        idle(3);
        chk("R2 no accept off boundary", accept, 0);
        chk("R8 mode 1", mode, 1);
        bnd(0, 0, 0, 0, 2'd0);
        chk("R9 kind m1", kind, 2);
        chk("R9 target m1", target, 16'h0038);
        bnd(0, 0, 0, 1, 2'd3);
        chk("R8 code 3 ignored", mode, 1);

        // R9 mode 2 sweep over every device byte
        bnd(0, 0, 0, 1, 2'd2);
        chk("R8 mode 2", mode, 2);
        for (int v = 0; v < 256; v++) begin
            int_n = 1'b1;
            bnd(1, 0, 0, 0, 2'd0);
            int_n = 1'b0; i_reg = 8'(v) ^ 8'hA5; dev_vec = 8'(v);
            bnd(0, 0, 0, 0, 2'd0);
            chk("R9 im2 accept", accept, 1);
            chk("R9 im2 kind", kind, 3);
            chk("R9 im2 target", target, {8'(v) ^ 8'hA5, 8'(v)});
        end

        // R6 level not latched
        int_n = 1'b1;
        bnd(1, 0, 0, 0, 2'd0);
        int_n = 1'b0; idle(2); int_n = 1'b1;
        bnd(0, 0, 0, 0, 2'd0);
        chk("R6 int released before boundary", accept, 0);

        // R4 R5 NMI over INT with iff1 set
        @(negedge clk); nmi_n = 1'b0; int_n = 1'b0;
        bnd(0, 0, 0, 0, 2'd0);
        chk("R4 nmi accepted", accept, 1);
        chk("R5 nmi kind", kind, 0);
        chk("R5 nmi target", target, 16'h0066);
        chk("R5 iff1 cleared", iff1, 0);
        chk("R5 iff2 holds old iff1", iff2, 1);
        bnd(0, 0, 0, 0, 2'd0);
        chk("R3 held low no retrigger", accept, 0);
        int_n = 1'b1;
        bnd(0, 0, 1, 0, 2'd0);
        chk("R11 retn restores iff1", iff1, 1);
        int_n = 1'b0;
        bnd(0, 1, 0, 0, 2'd0);
        chk("R7 di boundary no int", accept, 0);
        chk("R7 di iff1", iff1, 0);
        chk("R7 di iff2", iff2, 0);
        @(negedge clk); nmi_n = 1'b1;
        @(negedge clk); nmi_n = 1'b0;
        idle(5);
        chk("R3 pending waits for boundary", accept, 0);
        bnd(0, 0, 0, 0, 2'd0);
        chk("R4 nmi despite iff1 clear", accept, 1);
        chk("R4 nmi kind", kind, 0);
        chk("R5 iff2 copies cleared iff1", iff2, 0);
        bnd(0, 0, 0, 0, 2'd0);
        chk("R3 latch consumed", accept, 0);
        // R11 retn with int low at same boundary: flags applied first
        bnd(1, 0, 0, 0, 2'd0);
        int_n = 1'b1;
        @(negedge clk); nmi_n = 1'b1;
        @(negedge clk); nmi_n = 1'b0;
        bnd(0, 0, 0, 0, 2'd0);
        chk("R5 nmi again", kind, 0);
        int_n = 1'b0;
        bnd(0, 0, 1, 0, 2'd0);
        chk("R11 R12 retn then int same boundary", accept, 1);
        chk("R11 kind m2", kind, 3);
        finish_run();
    end
endmodule